// File: doc/BRIEF.md
# Automatic Xon/Xoff Flow Controller

This block carries out in-band software flow control beside a UART. On the receive side it compares the fill level of the receive FIFO with two programmable limits. When the level climbs above the upper limit it asks the transmitter to send the stop character, or the two-byte stop sequence. When the level later drops under the lower limit it asks for the resume character or sequence. It also inspects every received character. Stop and resume characters from the far end pause and release the local transmitter's data path, and those characters never reach the receive data stream.

Three small state machines make up the design.

The receive filter has three states:
- `FS_IDLE` waits for a byte.
- `FS_HOLD` keeps a first byte that matched and waits for the second byte in two-byte mode.
- `FS_SPILL` releases the second byte of a failed two-byte match.

Its transitions are IDLE→HOLD (first byte matched in two-byte mode), HOLD→IDLE (second byte matched), HOLD→SPILL (second byte did not match), SPILL→IDLE (always), and any state→IDLE (control disabled).

The level monitor has two states, `LS_RUN` and `LS_HALTED`. RUN→HALTED fires on level above the upper limit. HALTED→RUN fires on level below the lower limit. Both wait while a flow character is still being sent, and disabling forces RUN.

The transmit arbiter has three states:
- `TS_IDLE` passes host data.
- `TS_FLOW1` requests the first flow character.
- `TS_FLOW2` requests the second.

Its transitions are IDLE→FLOW1 (monitor request), FLOW1→FLOW2 (accepted in two-byte mode), FLOW1→IDLE (accepted in one-byte mode) and FLOW2→IDLE (accepted).

Received characters must be at least two clock cycles apart, which is always true of a serial receiver. Thresholds are byte counts from 0 to the FIFO depth (default 128).

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset `tx_req`, `dat_ready`, `out_valid` and `remote_paused` are all 0.
- R2: With control enabled, a level strictly greater than `cfg_hi_thr` makes the block request `cfg_xoff1` on `tx_byte`. A level equal to `cfg_hi_thr` requests nothing.
- R3: After a stop has been sent, a level strictly below `cfg_lo_thr` makes the block request `cfg_xon1`. A level equal to `cfg_lo_thr` requests nothing.
- R4: With `cfg_dual`=1 a stop is sent as `cfg_xoff1` followed by `cfg_xoff2`, and a resume as `cfg_xon1` followed by `cfg_xon2`, each byte on its own request/acknowledge.
- R5: While a flow character is waiting, it occupies `tx_byte` even if host data is offered, and `dat_ready` stays 0. Host data is passed once the flow character is accepted.
- R6: In one-byte mode a received `cfg_xoff1` sets `remote_paused` and is not forwarded on `out_valid`. While paused, host data raises no `tx_req`.
- R7: In one-byte mode a received `cfg_xon1` clears `remote_paused`, is not forwarded, and lets waiting host data be requested again.
- R8: In two-byte mode `cfg_xoff1`,`cfg_xoff2` received back to back pauses, and `cfg_xon1`,`cfg_xon2` resumes; neither pair is forwarded. If the second byte fails to match, the held first byte is forwarded one cycle after the second arrives, and the second byte one cycle after that.
- R9: With `cfg_en`=0 every received byte is forwarded, `remote_paused` is cleared, and the FIFO level causes no flow character.
- R10: Each crossing of a threshold produces exactly one stop or resume transmission, however long the level stays beyond it.
- R11: Flow characters are still requested while `remote_paused` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Software flow control enable |
| cfg_dual | input | 1 | 1 = two-byte flow sequences, 0 = single byte |
| cfg_xon1 | input | DATA_W | First (or only) resume byte |
| cfg_xon2 | input | DATA_W | Second resume byte |
| cfg_xoff1 | input | DATA_W | First (or only) stop byte |
| cfg_xoff2 | input | DATA_W | Second stop byte |
| cfg_hi_thr | input | LVL_W | Upper fill limit; stop sent when level exceeds it |
| cfg_lo_thr | input | LVL_W | Lower fill limit; resume sent when level falls under it |
| fifo_level | input | LVL_W | Current receive FIFO fill count |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| out_valid | output | 1 | Forwarded data strobe toward the receive FIFO |
| out_data | output | DATA_W | Forwarded data byte |
| remote_paused | output | 1 | Far end has asked this side to stop sending |
| dat_valid | input | 1 | Host offers a byte for transmission |
| dat_byte | input | DATA_W | Host byte |
| dat_ready | output | 1 | Host byte taken this cycle |
| tx_req | output | 1 | Request to the transmitter |
| tx_byte | output | DATA_W | Byte offered to the transmitter |
| tx_ack | input | 1 | Transmitter accepts `tx_byte` this cycle |

## Verification
Each result has a fixed latency after its stimulus:
- A received byte affects `out_valid`, `out_data` and `remote_paused` at the first clock edge that samples it. The second byte of a failed two-byte match follows on the next edge.
- A threshold crossing reaches `tx_req` after two edges: one to register the monitor's decision and one to move the arbiter.
- `dat_ready` and the next `tx_byte` follow `tx_ack` combinationally. The state change takes effect on the edge that samples the acknowledge.

The bench changes inputs on falling edges, advances the stated number of rising edges, and samples on the next falling edge. It holds the level beyond a threshold for several extra cycles to show that nothing further is requested.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    typedef enum logic [1:0] {FS_IDLE, FS_HOLD, FS_SPILL} filt_st_t;
    typedef enum logic       {LS_RUN, LS_HALTED}         lvl_st_t;
    typedef enum logic [1:0] {TS_IDLE, TS_FLOW1, TS_FLOW2} tx_st_t;
    typedef enum logic       {FC_XON = 1'b0, FC_XOFF = 1'b1} fc_kind_t;
endpackage

// File: rtl/xfc_rx_filter.sv
module xfc_rx_filter
    import xfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_dual,
    input  logic [DATA_W-1:0] cfg_xon1,
    input  logic [DATA_W-1:0] cfg_xon2,
    input  logic [DATA_W-1:0] cfg_xoff1,
    input  logic [DATA_W-1:0] cfg_xoff2,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              remote_paused
);
    filt_st_t          st_q, st_d;
    fc_kind_t          kind_q, kind_d;
    logic [DATA_W-1:0] held_q, held_d;
    logic [DATA_W-1:0] spill_q, spill_d;
    logic [DATA_W-1:0] od_d;
    logic              ov_d, pause_d;
    logic              hit_off, hit_on, second_ok;

    assign hit_off   = (rx_data == cfg_xoff1);
    assign hit_on    = (rx_data == cfg_xon1);
    assign second_ok = (kind_q == FC_XOFF) ? (rx_data == cfg_xoff2)
                                           : (rx_data == cfg_xon2);

    always_comb begin
        st_d    = st_q;
        kind_d  = kind_q;
        held_d  = held_q;
        spill_d = spill_q;
        ov_d    = 1'b0;
        od_d    = out_data;
        pause_d = remote_paused;
        if (!cfg_en) begin
            st_d    = FS_IDLE;
            pause_d = 1'b0;
            ov_d    = rx_valid;
            if (rx_valid) od_d = rx_data;
        end else begin
            unique case (st_q)
                FS_IDLE: begin
                    if (rx_valid) begin
                        if (hit_off || hit_on) begin
                            if (cfg_dual) begin
                                st_d   = FS_HOLD;
                                held_d = rx_data;
                                kind_d = hit_off ? FC_XOFF : FC_XON;
                            end else begin
                                pause_d = hit_off;
                            end
                        end else begin
                            ov_d = 1'b1;
                            od_d = rx_data;
                        end
                    end
                end
                FS_HOLD: begin
                    if (rx_valid) begin
                        if (second_ok) begin
                            pause_d = (kind_q == FC_XOFF);
                            st_d    = FS_IDLE;
                        end else begin
                            ov_d    = 1'b1;
                            od_d    = held_q;
                            spill_d = rx_data;
                            st_d    = FS_SPILL;
                        end
                    end
                end
                FS_SPILL: begin
                    ov_d = 1'b1;
                    od_d = spill_q;
                    st_d = FS_IDLE;
                end
                default: st_d = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q        <= FC_XON;
            held_q        <= '0;
            spill_q       <= '0;
            out_valid     <= 1'b0;
            out_data      <= '0;
            remote_paused <= 1'b0;
        end else begin
            kind_q        <= kind_d;
            held_q        <= held_d;
            spill_q       <= spill_d;
            out_valid     <= ov_d;
            out_data      <= od_d;
            remote_paused <= pause_d;
        end
    end

    // R9
    disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !remote_paused);

    // R8
    spill_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_SPILL) |-> ($past(st_q) == FS_HOLD));
endmodule

// File: rtl/xfc_lvl_monitor.sv
module xfc_lvl_monitor
    import xfc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] cfg_hi_thr,
    input  logic [LVL_W-1:0] cfg_lo_thr,
    input  logic             busy,
    output logic             go,
    output fc_kind_t         go_kind
);
    lvl_st_t  st_q, st_d;
    fc_kind_t kind_d;
    logic     go_d;

    always_comb begin
        st_d   = st_q;
        go_d   = 1'b0;
        kind_d = go_kind;
        if (!cfg_en) begin
            st_d = LS_RUN;
        end else if (!go && !busy) begin
            unique case (st_q)
                LS_RUN: begin
                    if (fifo_level > cfg_hi_thr) begin
                        st_d   = LS_HALTED;
                        go_d   = 1'b1;
                        kind_d = FC_XOFF;
                    end
                end
                LS_HALTED: begin
                    if (fifo_level < cfg_lo_thr) begin
                        st_d   = LS_RUN;
                        go_d   = 1'b1;
                        kind_d = FC_XON;
                    end
                end
                default: st_d = LS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LS_RUN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go      <= 1'b0;
            go_kind <= FC_XON;
        end else begin
            go      <= go_d;
            go_kind <= kind_d;
        end
    end

    // R10
    one_go_per_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st_q != $past(st_q)));
endmodule

// File: rtl/xfc_tx_arb.sv
module xfc_tx_arb
    import xfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual,
    input  logic [DATA_W-1:0] cfg_xon1,
    input  logic [DATA_W-1:0] cfg_xon2,
    input  logic [DATA_W-1:0] cfg_xoff1,
    input  logic [DATA_W-1:0] cfg_xoff2,
    input  logic              go,
    input  fc_kind_t          go_kind,
    input  logic              remote_paused,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_byte,
    output logic              dat_ready,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_ack,
    output logic              busy
);
    tx_st_t   st_q, st_d;
    fc_kind_t kind_q, kind_d;

    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        unique case (st_q)
            TS_IDLE: begin
                if (go) begin
                    st_d   = TS_FLOW1;
                    kind_d = go_kind;
                end
            end
            TS_FLOW1: if (tx_ack) st_d = cfg_dual ? TS_FLOW2 : TS_IDLE;
            TS_FLOW2: if (tx_ack) st_d = TS_IDLE;
            default:  st_d = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TS_IDLE;
            kind_q <= FC_XON;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
        end
    end

    always_comb begin
        tx_req    = 1'b0;
        tx_byte   = dat_byte;
        dat_ready = 1'b0;
        unique case (st_q)
            TS_IDLE: begin
                tx_req    = dat_valid && !remote_paused && !go;
                dat_ready = tx_req && tx_ack;
            end
            TS_FLOW1: begin
                tx_req  = 1'b1;
                tx_byte = (kind_q == FC_XOFF) ? cfg_xoff1 : cfg_xon1;
            end
            TS_FLOW2: begin
                tx_req  = 1'b1;
                tx_byte = (kind_q == FC_XOFF) ? cfg_xoff2 : cfg_xon2;
            end
            default: tx_req = 1'b0;
        endcase
    end

    assign busy = (st_q != TS_IDLE);

    // R5
    flow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dat_ready);

    // R6
    paused_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> !remote_paused);

    // R4
    second_after_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_FLOW2) |-> ($past(st_q) != TS_IDLE));
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_dual,
    input  logic [DATA_W-1:0] cfg_xon1,
    input  logic [DATA_W-1:0] cfg_xon2,
    input  logic [DATA_W-1:0] cfg_xoff1,
    input  logic [DATA_W-1:0] cfg_xoff2,
    input  logic [LVL_W-1:0]  cfg_hi_thr,
    input  logic [LVL_W-1:0]  cfg_lo_thr,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              remote_paused,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_byte,
    output logic              dat_ready,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_ack
);
    logic     go, busy;
    fc_kind_t go_kind;

    xfc_rx_filter #(.DATA_W(DATA_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dual(cfg_dual),
        .cfg_xon1(cfg_xon1), .cfg_xon2(cfg_xon2),
        .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data),
        .remote_paused(remote_paused)
    );

    xfc_lvl_monitor #(.LVL_W(LVL_W)) u_monitor (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
        .fifo_level(fifo_level), .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
        .busy(busy), .go(go), .go_kind(go_kind)
    );

    xfc_tx_arb #(.DATA_W(DATA_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
        .cfg_xon1(cfg_xon1), .cfg_xon2(cfg_xon2),
        .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
        .go(go), .go_kind(go_kind), .remote_paused(remote_paused),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack), .busy(busy)
    );
endmodule

// File: tb/sim_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module sim_xonxoff_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b1, cfg_dual = 1'b0;
    logic [7:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h91, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h93;
    logic [7:0] cfg_hi_thr = 8'd100, cfg_lo_thr = 8'd20, fifo_level = 8'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       out_valid, remote_paused, dat_ready, tx_req;
    logic [7:0] out_data, tx_byte;
    logic       dat_valid = 1'b0;
    logic [7:0] dat_byte = 8'h00;
    logic       tx_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xonxoff_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dual(cfg_dual),
        .cfg_xon1(cfg_xon1), .cfg_xon2(cfg_xon2), .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
        .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .fifo_level(fifo_level),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .out_valid(out_valid), .out_data(out_data), .remote_paused(remote_paused),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack)
    );

    // {rx byte, expected out_valid, expected out_data, expected remote_paused}
    localparam logic [17:0] VEC [6] = '{
        {8'h41, 1'b1, 8'h41, 1'b0},
        {8'h13, 1'b0, 8'h41, 1'b1},
        {8'h42, 1'b1, 8'h42, 1'b1},
        {8'h11, 1'b0, 8'h42, 1'b0},
        {8'h00, 1'b1, 8'h00, 1'b0},
        {8'h91, 1'b1, 8'h91, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic ack_once();
        tx_ack = 1'b1;
        tick();
        tx_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 tx_req", tx_req, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 remote_paused", remote_paused, 0);
        chk("R1 dat_ready", dat_ready, 0);
        tick();

        // R6 R7 vector walk, single-byte mode
        for (int v = 0; v < 6; v++) begin
            send_rx(VEC[v][17:10]);
            chk("R6/R7 vec out_valid", out_valid, VEC[v][9]);
            if (VEC[v][9]) chk("R6/R7 vec out_data", out_data, VEC[v][8:1]);
            chk("R6/R7 vec paused", remote_paused, VEC[v][0]);
            tick();
        end

        // R6 paused blocks host data
        send_rx(8'h13);
        tick();
        dat_valid = 1'b1;
        dat_byte  = 8'h55;
        #0;
        chk("R6 no tx_req while paused", tx_req, 0);
        tx_ack = 1'b1;
        #0;
        chk("R6 no dat_ready while paused", dat_ready, 0);
        tx_ack = 1'b0;
        // R7 resume releases data
        send_rx(8'h11);
        chk("R7 tx_req after resume", tx_req, 1);
        chk("R7 tx_byte data", tx_byte, 8'h55);
        dat_valid = 1'b0;
        tick();

        // R2 equal to upper limit: nothing
        fifo_level = 8'd100;
        tick(4);
        chk("R2 level==hi no request", tx_req, 0);
        fifo_level = 8'd101;
        tick(2);
        chk("R2 stop requested", tx_req, 1);
        chk("R2 stop byte", tx_byte, 8'h13);
        // R5 flow character ahead of host data
        dat_valid = 1'b1;
        dat_byte  = 8'h66;
        tx_ack    = 1'b1;
        #0;
        chk("R5 flow byte holds tx_byte", tx_byte, 8'h13);
        chk("R5 dat_ready low", dat_ready, 0);
        tick();
        tx_ack = 1'b0;
        #0;
        chk("R5 data after flow char", tx_byte, 8'h66);
        chk("R5 data requested", tx_req, 1);
        dat_valid = 1'b0;
        // R10 no repeat while level stays high
        tick(6);
        chk("R10 single stop only", tx_req, 0);

        // R3 lower limit
        fifo_level = 8'd20;
        tick(4);
        chk("R3 level==lo no request", tx_req, 0);
        fifo_level = 8'd19;
        tick(2);
        chk("R3 resume requested", tx_req, 1);
        chk("R3 resume byte", tx_byte, 8'h11);
        ack_once();
        tick(4);
        chk("R10 single resume only", tx_req, 0);

        // R11 flow chars still go out while paused
        send_rx(8'h13);
        chk("R11 paused set", remote_paused, 1);
        tick();
        fifo_level = 8'd101;
        tick(2);
        chk("R11 stop while paused", tx_req, 1);
        chk("R11 stop byte while paused", tx_byte, 8'h13);
        ack_once();
        send_rx(8'h11);
        tick();
        fifo_level = 8'd19;
        tick(2);
        chk("R11 resume byte", tx_byte, 8'h11);
        ack_once();
        tick();

        // R4 two-byte sequences
        cfg_dual = 1'b1;
        fifo_level = 8'd101;
        tick(2);
        chk("R4 first stop byte", tx_byte, 8'h13);
        ack_once();
        chk("R4 second stop req", tx_req, 1);
        chk("R4 second stop byte", tx_byte, 8'h93);
        ack_once();
        chk("R4 stop done", tx_req, 0);
        fifo_level = 8'd19;
        tick(2);
        chk("R4 first resume byte", tx_byte, 8'h11);
        ack_once();
        chk("R4 second resume byte", tx_byte, 8'h91);
        ack_once();
        chk("R4 resume done", tx_req, 0);

        // R8 two-byte receive matching
        send_rx(8'h13);
        chk("R8 first byte held", out_valid, 0);
        chk("R8 not yet paused", remote_paused, 0);
        tick();
        send_rx(8'h93);
        chk("R8 pair dropped", out_valid, 0);
        chk("R8 pair pauses", remote_paused, 1);
        tick();
        send_rx(8'h11);
        tick();
        send_rx(8'h91);
        chk("R8 resume pair", remote_paused, 0);
        chk("R8 resume pair dropped", out_valid, 0);
        tick();
        send_rx(8'h13);
        tick();
        send_rx(8'h44);
        chk("R8 mismatch first valid", out_valid, 1);
        chk("R8 mismatch first byte", out_data, 8'h13);
        tick();
        chk("R8 mismatch second valid", out_valid, 1);
        chk("R8 mismatch second byte", out_data, 8'h44);
        tick();
        chk("R8 mismatch done", out_valid, 0);

        // R9 disable
        send_rx(8'h13);
        tick();
        send_rx(8'h93);
        tick();
        cfg_en = 1'b0;
        tick();
        chk("R9 pause cleared", remote_paused, 0);
        send_rx(8'h13);
        chk("R9 stop byte forwarded", out_valid, 1);
        chk("R9 stop byte value", out_data, 8'h13);
        fifo_level = 8'd101;
        tick(4);
        chk("R9 level ignored", tx_req, 0);

        finish_run();
    end
endmodule